// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a 16-pin general-purpose I/O controller on a simple 32-bit word-addressed register bus. Software owns an output value register and an output-enable register. Each of the two has an alias where written ones set bits and another where written ones clear bits, so a single bus write can change some pins without a read-modify-write. Pin inputs pass through a synchronizer. The synchronized levels can be read back, and they feed a per-pin event detector. The detector records rising, falling, either-edge, low-level or high-level events in an interrupt status register, which also has set and clear aliases.

Every pin has its own configuration word. The word selects the event type, open-drain emulation (the pad is driven low only while the output value is 0, and is released otherwise), where the output value comes from (the data register or a shared sigma-delta bitstream input), and whether a level condition on that pin may request a CPU wake-up. The interrupt line is the OR of all status bits. The upper halves of the output and enable words are plain read/write storage with no function.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, pin_oe is all 0, and irq and wake are 0.
- R2: Word 0 reads and writes the output value in bits [15:0] and plain storage in bits [31:16]. A write to word 1 sets each output bit whose write bit is 1, and a write to word 2 clears each such bit. Neither alias touches bits [31:16].
- R3: Word 3 holds the output enable in bits [15:0], with upper storage. Word 4 is its write-ones-set alias and word 5 is its write-ones-clear alias.
- R4: Word 6 returns in bits [15:0] the pin levels after two clock edges of synchronization. A level applied before edge k is visible after edge k+1.
- R5: Event type codes sit in configuration bits [9:7]: 1 rising, 2 falling, 3 either edge. An edge sets the status bit one edge after it becomes visible in word 6, that is after edge k+2.
- R6: Type 4 (low) and type 5 (high) set the status bit on every edge while the synchronized level matches. A software clear in that interval does not stick, because hardware setting wins.
- R7: Word 7 reads and writes the status bits [15:0]. A write to word 8 sets the written-one bits and a write to word 9 clears them. irq is 1 exactly when some status bit is 1.
- R8: Type codes 0, 6 and 7 never set a status bit.
- R9: wake is 1 while some pin has configuration bit 10 set, type 4 or 5, and a synchronized level that matches its type. Edge types never raise wake.
- R10: With configuration bit 2 set, pin_oe for that pin is 1 only when the enable bit is 1 and the selected value is 0, and pin_out is then 0.
- R11: With configuration bit 0 set, the pin's output value is the sd_bit input, ignoring the output data bit. With bit 0 clear, the output data bit is used.
- R12: Configuration words sit at word 10+n for pin n. They keep only bits 10, 9:7, 2 and 0, and all other bits read 0. Words 1, 2, 4, 5, 8, 9 and words 26 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| bus_wr | input | 1 | Write strobe, commits on the rising clock edge |
| bus_addr | input | AW (5) | Word offset for read and write |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for bus_addr |
| pin_in | input | NPIN (16) | Raw pin levels |
| sd_bit | input | 1 | Shared sigma-delta bitstream |
| pin_out | output | NPIN (16) | Value to the pads |
| pin_oe | output | NPIN (16) | Pad drive enable |
| irq | output | 1 | OR of status bits |
| wake | output | 1 | Level-qualified wake-up request |

## Verification
A wrong previous-sample flop or synchronizer stage shows at the ports as a status bit that appears one edge early or late after a pin change, so irq is sampled on both sides of the expected edge. A corrupted configuration word shows at once in pin_oe and pin_out through the open-drain and source paths, and at wake, which is combinational from the configuration. A status update that loses the priority of hardware setting is exposed by a clear during an active level, which must read back still set on the very next read. A reference model in the bench tracks every register edge by edge under random traffic, so any drift shows within one cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // word offsets on the register bus
   localparam int OFS_OUT     = 0;
   localparam int OFS_OUT_SET = 1;
   localparam int OFS_OUT_CLR = 2;
   localparam int OFS_OE      = 3;
   localparam int OFS_OE_SET  = 4;
   localparam int OFS_OE_CLR  = 5;
   localparam int OFS_LEVEL   = 6;
   localparam int OFS_ST      = 7;
   localparam int OFS_ST_SET  = 8;
   localparam int OFS_ST_CLR  = 9;
   localparam int OFS_CFG0    = 10;

   // event type codes
   localparam logic [2:0] TRIG_NONE = 3'd0;
   localparam logic [2:0] TRIG_RISE = 3'd1;
   localparam logic [2:0] TRIG_FALL = 3'd2;
   localparam logic [2:0] TRIG_BOTH = 3'd3;
   localparam logic [2:0] TRIG_LOW  = 3'd4;
   localparam logic [2:0] TRIG_HIGH = 3'd5;

   // configuration field positions
   localparam int CF_SRC  = 0;
   localparam int CF_OD   = 2;
   localparam int CF_TRIG = 7;
   localparam int CF_WAKE = 10;

   typedef struct packed {
      logic       wake_en;
      logic [2:0] trig;
      logic       open_drain;
      logic       use_sd;
   } pin_cfg_t;

   function automatic pin_cfg_t cfg_from_word(input logic [31:0] w);
      pin_cfg_t c;
      c.wake_en    = w[CF_WAKE];
      c.trig       = w[CF_TRIG+2:CF_TRIG];
      c.open_drain = w[CF_OD];
      c.use_sd     = w[CF_SRC];
      return c;
   endfunction

   function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
      logic [31:0] w;
      w = '0;
      w[CF_WAKE]            = c.wake_en;
      w[CF_TRIG+2:CF_TRIG]  = c.trig;
      w[CF_OD]              = c.open_drain;
      w[CF_SRC]             = c.use_sd;
      return w;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("gpio_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_evt.sv
module gpio_pin_evt
   import gpio_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cur,
   input  logic [2:0] trig,
   output logic       hit,
   output logic       lvl_met
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;

   always_comb begin
      case (trig)
         TRIG_RISE: hit = rise;
         TRIG_FALL: hit = fall;
         TRIG_BOTH: hit = rise | fall;
         TRIG_LOW:  hit = ~cur;
         TRIG_HIGH: hit = cur;
         default:   hit = 1'b0;
      endcase
   end

   assign lvl_met = ((trig == TRIG_LOW) & ~cur) | ((trig == TRIG_HIGH) & cur);

   // R5: a synchronized rising transition under a rising type must fire
   p_edge_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig == TRIG_RISE && cur && !$past(cur)) |-> hit);

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
   import gpio_irq_pkg::*;
#(
   parameter bit OD_EN = 1'b1
) (
   input  logic     data,
   input  logic     oe,
   input  logic     sd,
   input  pin_cfg_t cfg,
   output logic     pad_o,
   output logic     pad_oe
);
   logic val;

   assign val = cfg.use_sd ? sd : data;

   generate
      if (OD_EN) begin : g_od
         assign pad_oe = oe & ~(cfg.open_drain & val);
         assign pad_o  = val & ~cfg.open_drain;

         // R10: an open-drain pin holding a 1 must be released
         always_comb begin
            if (cfg.open_drain && val) begin
               p_od_release_r10: assert (!pad_oe);
            end
         end
      end else begin : g_push_pull
         assign pad_oe = oe;
         assign pad_o  = val;
      end
   endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NPIN        = 16,
   parameter int DW          = 32,
   parameter int AW          = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit OD_EN       = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NPIN-1:0] pin_in,
   input  logic            sd_bit,
   output logic [NPIN-1:0] pin_out,
   output logic [NPIN-1:0] pin_oe,
   output logic            irq,
   output logic            wake
);
   localparam int HI_LO    = 16;
   localparam int HI_W     = DW - HI_LO;
   localparam int CFG_LAST = OFS_CFG0 + NPIN - 1;

   generate
      if (NPIN < 1 || NPIN > 16) begin : g_bad_npin
         $error("gpio_irq_ctrl: NPIN must be 1..16");
      end
      if (DW < 32) begin : g_bad_dw
         $error("gpio_irq_ctrl: DW must be at least 32");
      end
      if ((1 << AW) <= CFG_LAST) begin : g_bad_aw
         $error("gpio_irq_ctrl: AW too small for the register map");
      end
   endgenerate

   logic [NPIN-1:0] out_q, oe_q, st_q, st_d;
   logic [HI_W-1:0] out_hi_q, oe_hi_q;
   pin_cfg_t        cfg_q [NPIN];
   logic [NPIN-1:0] s_pin, hit, lvl, wk;
   logic [NPIN-1:0] wlo;

   assign wlo = bus_wdata[NPIN-1:0];

   function automatic logic sel(input logic [AW-1:0] a, input int ofs);
      return a == AW'(ofs);
   endfunction

   // ---------------- input synchronizer ----------------
   gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (s_pin)
   );

   // ---------------- output value / enable ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q    <= '0;
         out_hi_q <= '0;
      end else if (bus_wr) begin
         if (sel(bus_addr, OFS_OUT)) begin
            out_q    <= wlo;
            out_hi_q <= bus_wdata[DW-1:HI_LO];
         end else if (sel(bus_addr, OFS_OUT_SET)) begin
            out_q <= out_q | wlo;
         end else if (sel(bus_addr, OFS_OUT_CLR)) begin
            out_q <= out_q & ~wlo;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q    <= '0;
         oe_hi_q <= '0;
      end else if (bus_wr) begin
         if (sel(bus_addr, OFS_OE)) begin
            oe_q    <= wlo;
            oe_hi_q <= bus_wdata[DW-1:HI_LO];
         end else if (sel(bus_addr, OFS_OE_SET)) begin
            oe_q <= oe_q | wlo;
         end else if (sel(bus_addr, OFS_OE_CLR)) begin
            oe_q <= oe_q & ~wlo;
         end
      end
   end

   // ---------------- per-pin configuration ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NPIN; i++) cfg_q[i] <= '0;
      end else begin
         for (int i = 0; i < NPIN; i++) begin
            if (bus_wr && sel(bus_addr, OFS_CFG0 + i))
               cfg_q[i] <= cfg_from_word(bus_wdata[31:0]);
         end
      end
   end

   // ---------------- interrupt status ----------------
   always_comb begin
      st_d = st_q;
      if (bus_wr) begin
         if (sel(bus_addr, OFS_ST))          st_d = wlo;
         else if (sel(bus_addr, OFS_ST_SET)) st_d = st_q | wlo;
         else if (sel(bus_addr, OFS_ST_CLR)) st_d = st_q & ~wlo;
      end
      st_d = st_d | hit;   // hardware events win over software
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   // ---------------- per-pin slices ----------------
   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      gpio_pin_evt u_evt (
         .clk     (clk),
         .rst_n   (rst_n),
         .cur     (s_pin[i]),
         .trig    (cfg_q[i].trig),
         .hit     (hit[i]),
         .lvl_met (lvl[i])
      );

      gpio_pad_mux #(.OD_EN(OD_EN)) u_pad (
         .data   (out_q[i]),
         .oe     (oe_q[i]),
         .sd     (sd_bit),
         .cfg    (cfg_q[i]),
         .pad_o  (pin_out[i]),
         .pad_oe (pin_oe[i])
      );

      assign wk[i] = cfg_q[i].wake_en & lvl[i];

      // R8: an unused type code leaves a clear status bit clear
      p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_wr && !st_q[i] && (cfg_q[i].trig == TRIG_NONE || cfg_q[i].trig > TRIG_HIGH))
         |=> !st_q[i]);
   end

   assign irq  = |st_q;
   assign wake = |wk;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (sel(bus_addr, OFS_OUT)) begin
         bus_rdata[NPIN-1:0]     = out_q;
         bus_rdata[DW-1:HI_LO]   = out_hi_q;
      end else if (sel(bus_addr, OFS_OE)) begin
         bus_rdata[NPIN-1:0]     = oe_q;
         bus_rdata[DW-1:HI_LO]   = oe_hi_q;
      end else if (sel(bus_addr, OFS_LEVEL)) begin
         bus_rdata[NPIN-1:0]     = s_pin;
      end else if (sel(bus_addr, OFS_ST)) begin
         bus_rdata[NPIN-1:0]     = st_q;
      end
      for (int i = 0; i < NPIN; i++) begin
         if (sel(bus_addr, OFS_CFG0 + i)) bus_rdata[31:0] = cfg_to_word(cfg_q[i]);
      end
   end

   // ---------------- assertions ----------------
   // R6: every detected event is recorded on the next edge
   p_hw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((st_q & $past(hit)) == $past(hit)));

   // R7: clearing through the alias takes effect where no event competes
   p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel(bus_addr, OFS_ST_CLR)) |=> ((st_q & $past(wlo & ~hit)) == '0));

   // R9: a wake request needs a met level condition on some pin
   p_wake_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (|lvl));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic        sd_bit = 1'b0;
   logic [15:0] pin_out, pin_oe;
   logic        irq, wake;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .sd_bit(sd_bit), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake)
   );

   // ---------------- reference model ----------------
   logic [15:0] m_s1, m_s2, m_prev, m_out, m_oe, m_st, m_out_hi, m_oe_hi;
   logic [31:0] m_cfg [16];
   logic [15:0] m_h, m_nst;

   function automatic logic f_hit(input logic [31:0] cw, input logic c, input logic p);
      case (cw[9:7])
         3'd1: return c & ~p;
         3'd2: return ~c & p;
         3'd3: return c ^ p;
         3'd4: return ~c;
         3'd5: return c;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic f_lvl(input logic [31:0] cw, input logic c);
      return (cw[9:7] == 3'd4 && !c) || (cw[9:7] == 3'd5 && c);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_out <= '0; m_oe <= '0;
         m_st <= '0; m_out_hi <= '0; m_oe_hi <= '0;
         for (int i = 0; i < 16; i++) m_cfg[i] <= '0;
      end else begin
         for (int i = 0; i < 16; i++) m_h[i] = f_hit(m_cfg[i], m_s2[i], m_prev[i]);
         m_nst = m_st;
         if (bus_wr) begin
            case (bus_addr)
               5'd0: begin m_out <= bus_wdata[15:0]; m_out_hi <= bus_wdata[31:16]; end
               5'd1: m_out <= m_out | bus_wdata[15:0];
               5'd2: m_out <= m_out & ~bus_wdata[15:0];
               5'd3: begin m_oe <= bus_wdata[15:0]; m_oe_hi <= bus_wdata[31:16]; end
               5'd4: m_oe <= m_oe | bus_wdata[15:0];
               5'd5: m_oe <= m_oe & ~bus_wdata[15:0];
               5'd7: m_nst = bus_wdata[15:0];
               5'd8: m_nst = m_st | bus_wdata[15:0];
               5'd9: m_nst = m_st & ~bus_wdata[15:0];
               default: if (bus_addr >= 5'd10 && bus_addr <= 5'd25)
                           m_cfg[int'(bus_addr) - 10] <= bus_wdata & 32'h0000_0785;
            endcase
         end
         m_st <= m_nst | m_h;
         m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      end
   end

   function automatic logic [31:0] exp_read(input logic [4:0] a);
      case (a)
         5'd0: return {m_out_hi, m_out};
         5'd3: return {m_oe_hi, m_oe};
         5'd6: return {16'h0, m_s2};
         5'd7: return {16'h0, m_st};
         default: if (a >= 5'd10 && a <= 5'd25) return m_cfg[int'(a) - 10];
                  else return 32'h0;
      endcase
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic model_pads_chk(input string tag);
      logic [15:0] eo, eoe;
      logic        ew, v;
      ew = 1'b0;
      for (int i = 0; i < 16; i++) begin
         v      = m_cfg[i][0] ? sd_bit : m_out[i];
         eoe[i] = m_oe[i] & ~(m_cfg[i][2] & v);
         eo[i]  = v & ~m_cfg[i][2];
         ew     = ew | (m_cfg[i][10] & f_lvl(m_cfg[i], m_s2[i]));
      end
      chk({tag, " pin_out"}, {16'h0, pin_out}, {16'h0, eo});
      chk({tag, " pin_oe"},  {16'h0, pin_oe},  {16'h0, eoe});
      chk({tag, " irq"},     {31'h0, irq},     {31'h0, |m_st});
      chk({tag, " wake"},    {31'h0, wake},    {31'h0, ew});
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(64'd4_000_000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired got=hang exp=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd1234));
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk("R1 out", 5'd0, 32'h0);
      rd_chk("R1 oe", 5'd3, 32'h0);
      rd_chk("R1 status", 5'd7, 32'h0);
      rd_chk("R1 cfg", 5'd10, 32'h0);
      chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
      chk("R1 irq/wake", {30'h0, irq, wake}, 32'h0);

      // R2 output value and aliases
      wr(5'd0, 32'hABCD_1234);
      rd_chk("R2 write", 5'd0, 32'hABCD_1234);
      wr(5'd1, 32'h0000_00F0);
      rd_chk("R2 set", 5'd0, 32'hABCD_12F4);
      wr(5'd2, 32'h0000_0004);
      rd_chk("R2 clear", 5'd0, 32'hABCD_12F0);
      wr(5'd1, 32'hFFFF_0000);
      rd_chk("R2 upper untouched", 5'd0, 32'hABCD_12F0);

      // R3 output enable
      wr(5'd4, 32'h0000_000F);
      rd_chk("R3 set", 5'd3, 32'h0000_000F);
      chk("R3 pin_oe", {16'h0, pin_oe}, 32'h0000_000F);
      wr(5'd5, 32'h0000_0003);
      rd_chk("R3 clear", 5'd3, 32'h0000_000C);

      // R4 synchronizer latency
      pin_in = 16'hA5A5;
      cyc(1);
      rd_chk("R4 one edge", 5'd6, 32'h0);
      cyc(1);
      rd_chk("R4 two edges", 5'd6, 32'h0000_A5A5);
      pin_in = 16'h0;
      cyc(3);

      // R5 edges
      wr(5'd10, 32'h0000_0080);   // pin0 rising
      wr(5'd11, 32'h0000_0100);   // pin1 falling
      wr(5'd9, 32'h0000_FFFF);
      pin_in = 16'h0003;
      cyc(2);
      chk("R5 not yet", {31'h0, irq}, 32'h0);
      cyc(1);
      rd_chk("R5 rise", 5'd7, 32'h0000_0001);
      wr(5'd9, 32'h0000_0001);
      pin_in = 16'h0000;
      cyc(3);
      rd_chk("R5 fall", 5'd7, 32'h0000_0002);
      wr(5'd9, 32'h0000_0002);
      rd_chk("R7 clear edge bit", 5'd7, 32'h0);

      // R6 level re-arm
      wr(5'd12, 32'h0000_0280);   // pin2 high level
      pin_in = 16'h0004;
      cyc(3);
      rd_chk("R6 level set", 5'd7, 32'h0000_0004);
      wr(5'd9, 32'h0000_0004);
      rd_chk("R6 clear does not stick", 5'd7, 32'h0000_0004);
      pin_in = 16'h0000;
      cyc(3);
      wr(5'd9, 32'h0000_0004);
      rd_chk("R6 clear after level gone", 5'd7, 32'h0);

      // R7 status register and aliases
      wr(5'd7, 32'h0000_0100);
      rd_chk("R7 direct write", 5'd7, 32'h0000_0100);
      chk("R7 irq high", {31'h0, irq}, 32'h1);
      wr(5'd8, 32'h0000_0200);
      rd_chk("R7 set alias", 5'd7, 32'h0000_0300);
      wr(5'd9, 32'h0000_0300);
      rd_chk("R7 clear alias", 5'd7, 32'h0);
      chk("R7 irq low", {31'h0, irq}, 32'h0);

      // R8 unused codes
      wr(5'd13, 32'h0000_0300);   // pin3 code 6
      wr(5'd18, 32'h0000_0380);   // pin8 code 7
      for (int k = 0; k < 3; k++) begin
         pin_in = 16'h0108; cyc(3);
         pin_in = 16'h0000; cyc(3);
      end
      rd_chk("R8 no events", 5'd7, 32'h0);
      chk("R8 irq", {31'h0, irq}, 32'h0);

      // R9 wake qualification
      wr(5'd14, 32'h0000_0600);   // pin4 low level + wake
      chk("R9 wake low level", {31'h0, wake}, 32'h1);
      wr(5'd15, 32'h0000_0480);   // pin5 rising + wake
      pin_in = 16'h0010;
      cyc(2);
      chk("R9 wake drops", {31'h0, wake}, 32'h0);
      pin_in = 16'h0030;
      for (int k = 0; k < 3; k++) begin
         cyc(1);
         chk("R9 edge type no wake", {31'h0, wake}, 32'h0);
      end
      wr(5'd9, 32'h0000_FFFF);
      rd_chk("R9 cleanup", 5'd7, 32'h0);

      // R10 open drain on pin6 (out bit6 is 1)
      wr(5'd16, 32'h0000_0004);
      wr(5'd4, 32'h0000_0040);
      chk("R10 released on one", {31'h0, pin_oe[6]}, 32'h0);
      wr(5'd2, 32'h0000_0040);
      chk("R10 driven on zero", {30'h0, pin_oe[6], pin_out[6]}, 32'h2);

      // R11 sigma-delta source on pin7 (out bit7 is 1)
      wr(5'd17, 32'h0000_0001);
      wr(5'd4, 32'h0000_0080);
      sd_bit = 1'b0; #1;
      chk("R11 sd low", {31'h0, pin_out[7]}, 32'h0);
      wr(5'd2, 32'h0000_0080);
      sd_bit = 1'b1; #1;
      chk("R11 sd high", {31'h0, pin_out[7]}, 32'h1);

      // R12 configuration masking and empty words
      wr(5'd19, 32'hFFFF_FFFF);
      rd_chk("R12 cfg mask", 5'd19, 32'h0000_0785);
      rd_chk("R12 alias reads zero", 5'd8, 32'h0);
      rd_chk("R12 unmapped", 5'd26, 32'h0);

      // constrained random against the model
      for (int it = 0; it < 4000; it++) begin
         @(negedge clk);
         if ($urandom_range(3) == 0) pin_in = 16'($urandom);
         sd_bit = 1'($urandom);
         if ($urandom_range(4) == 0) begin
            bus_wr    = 1'b1;
            bus_addr  = 5'($urandom_range(25));
            bus_wdata = $urandom;
         end else begin
            bus_wr   = 1'b0;
            bus_addr = 5'($urandom_range(31));
         end
         #1;
         chk("R2/R3/R4/R7/R12 random read", bus_rdata, exp_read(bus_addr));
         model_pads_chk("R5/R6/R9/R10/R11 random");
      end
      bus_wr = 1'b0;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule